// File: doc/BRIEF.md
# UART Channel Interrupt Status Collector

This block gathers the interrupt causes of one UART channel into a single interrupt request line and a small code that names the most urgent cause still pending. It watches six causes: receive data ready, receive timeout, line status error, transmit ready, modem status change, and flow-control or special-character detection. Each cause is held in its own pending flag, and each flag has its own clearing rule. Some flags clear when a particular register is read. Others clear from a receive FIFO condition, and no register read affects them.

The surrounding channel logic supplies the receive FIFO fill level, its trigger threshold and its empty flag, single-cycle event pulses from the serial engines, and single-cycle strobes that mark reads of the line status, interrupt status and modem status registers. A six-bit enable register, loaded through a write strobe, masks the causes on their way to the outputs. A flag is still recorded while its enable bit is low. The asynchronous reset is released through a two-stage synchronizer.

Top module: `uart_irq_status`

## Requirements
- R1: After reset, and before any event, `irq_o` is 0, `irq_id` is 0 and all six enable bits are 0.
- R2: The receive-ready cause is pending whenever `rx_level >= rx_trig`, and it drops once the level falls below the trigger. No register read clears it.
- R3: A `line_err_pulse` sets the line-status cause, and only an `rd_lsr` strobe clears it.
- R4: A `rx_tmo_pulse` sets the receive-timeout cause, and only `rx_empty` high clears it. Register reads do not clear it.
- R5: A `tx_room_pulse` sets the transmit-ready cause, and only an `rd_isr` strobe clears it.
- R6: Either `modem_chg_pulse` or `hshk_chg_pulse` sets the modem-status cause, and only an `rd_msr` strobe clears it.
- R7: Either `xoff_chg_pulse` or `spec_chr_pulse` sets the flow/special cause, and only an `rd_isr` strobe clears it.
- R8: When a setting event and that cause's clearing condition occur in the same cycle, the cause stays pending.
- R9: An `en_we` strobe loads `en_wdata` into the enables. Bit 0 is line status, bit 1 receive timeout, bit 2 receive ready, bit 3 transmit ready, bit 4 modem status and bit 5 flow/special. `irq_o` is the OR of the pending causes whose enable bit is set. A disabled cause still records its pending state and shows up once it is enabled.
- R10: `irq_id` reports the highest-priority cause that is both enabled and pending: 1 line status, 2 receive timeout, 3 receive ready, 4 transmit ready, 5 modem status, 6 flow/special, and 0 for none. Smaller codes win.
- R11: Every input is sampled at a rising clock edge, and its effect appears on `irq_o` and `irq_id` right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive FIFO trigger threshold |
| rx_empty | input | 1 | Receive FIFO empty flag |
| rx_tmo_pulse | input | 1 | Receive timeout event |
| line_err_pulse | input | 1 | Line status error event |
| tx_room_pulse | input | 1 | Transmit ready event |
| modem_chg_pulse | input | 1 | Modem input change event |
| hshk_chg_pulse | input | 1 | Handshake pair delta event |
| xoff_chg_pulse | input | 1 | Xon/Xoff state change event |
| spec_chr_pulse | input | 1 | Special character detected |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_isr | input | 1 | Interrupt status register read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 6 | Enable register write data |
| irq_o | output | 1 | Combined interrupt request |
| irq_id | output | 3 | Code of the winning cause |

## Verification
Every pending flag and every enable bit is a register that updates at the edge where its input is sampled. `irq_o` and `irq_id` are combinational functions of those registers, so each result is due one rising edge after the stimulus. The bench drives inputs just after a falling edge and holds them across exactly one rising edge. It then reads the outputs at the next falling edge, which means each check sees the state that single edge produced. Checks for the "has no effect" cases apply the non-clearing read or condition for one edge and then read the unchanged code, before the real clearing stimulus is applied.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC = 6;
  localparam int ID_W = 3;

  // Source index; lower index = higher priority
  localparam int SRC_LINE  = 0;
  localparam int SRC_RXTO  = 1;
  localparam int SRC_RXRDY = 2;
  localparam int SRC_TXRDY = 3;
  localparam int SRC_MODEM = 4;
  localparam int SRC_FLOW  = 5;

  typedef enum logic [ID_W-1:0] {
    ID_NONE  = 3'd0,
    ID_LINE  = 3'd1,
    ID_RXTO  = 3'd2,
    ID_RXRDY = 3'd3,
    ID_TXRDY = 3'd4,
    ID_MODEM = 3'd5,
    ID_FLOW  = 3'd6
  } irq_id_e;
endpackage

// File: rtl/uart_irq_rst_sync.sv
module uart_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/uart_irq_flag.sv
// Sticky pending flag: a set in the same cycle as a clear wins.
module uart_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  logic pend_q;
  logic pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr_i) pend_d = 1'b0;
    if (set_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    id_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) id_o = ID_W'(i + 1);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             rx_empty,
  input  logic             rx_tmo_pulse,
  input  logic             line_err_pulse,
  input  logic             tx_room_pulse,
  input  logic             modem_chg_pulse,
  input  logic             hshk_chg_pulse,
  input  logic             xoff_chg_pulse,
  input  logic             spec_chr_pulse,
  input  logic             rd_lsr,
  input  logic             rd_isr,
  input  logic             rd_msr,
  input  logic             en_we,
  input  logic [NSRC-1:0]  en_wdata,
  output logic             irq_o,
  output logic [ID_W-1:0]  irq_id
);
  logic            rst_sync_n;
  logic [NSRC-1:0] set_v;
  logic [NSRC-1:0] clr_v;
  logic [NSRC-1:0] pend_v;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic [NSRC-1:0] masked_v;
  logic            lvl_hit;

  uart_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Set and clear conditions, one pair per source
  always_comb begin
    lvl_hit = (rx_level >= rx_trig);
    set_v = '0;
    clr_v = '0;
    set_v[SRC_LINE]  = line_err_pulse;
    clr_v[SRC_LINE]  = rd_lsr;
    set_v[SRC_RXTO]  = rx_tmo_pulse;
    clr_v[SRC_RXTO]  = rx_empty;
    set_v[SRC_RXRDY] = lvl_hit;
    clr_v[SRC_RXRDY] = ~lvl_hit;
    set_v[SRC_TXRDY] = tx_room_pulse;
    clr_v[SRC_TXRDY] = rd_isr;
    set_v[SRC_MODEM] = modem_chg_pulse | hshk_chg_pulse;
    clr_v[SRC_MODEM] = rd_msr;
    set_v[SRC_FLOW]  = xoff_chg_pulse | spec_chr_pulse;
    clr_v[SRC_FLOW]  = rd_isr;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    uart_irq_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (set_v[g]),
      .clr_i  (clr_v[g]),
      .pend_o (pend_v[g])
    );
  end

  // Enable register with explicit load enable
  always_comb begin
    en_d = en_q;
    if (en_we) en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else             en_q <= en_d;
  end

  always_comb masked_v = pend_v & en_q;

  uart_irq_prio #(.N(NSRC)) u_prio (
    .req_i (masked_v),
    .any_o (irq_o),
    .id_o  (irq_id)
  );
endmodule

// File: rtl/uart_irq_status_chk.sv
module uart_irq_status_chk
  import uart_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_sync_n,
  input logic            rx_empty,
  input logic            rx_tmo_pulse,
  input logic            line_err_pulse,
  input logic            tx_room_pulse,
  input logic            rd_lsr,
  input logic            rd_isr,
  input logic [NSRC-1:0] pend_v,
  input logic            irq_o,
  input logic [ID_W-1:0] irq_id
);
  // R3: a line error is pending after its edge
  a_r3_line_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_err_pulse |=> pend_v[SRC_LINE]);
  // R3: a status read without a new event clears it
  a_r3_line_clr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_lsr && !line_err_pulse) |=> !pend_v[SRC_LINE]);
  // R4: an empty FIFO without a new timeout clears the timeout cause
  a_r4_tmo_clr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_empty && !rx_tmo_pulse) |=> !pend_v[SRC_RXTO]);
  // R4: reads never drop a pending timeout while the FIFO holds data
  a_r4_tmo_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pend_v[SRC_RXTO] && !rx_empty) |=> pend_v[SRC_RXTO]);
  // R5: interrupt status read clears transmit ready
  a_r5_tx_clr: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_isr && !tx_room_pulse) |=> !pend_v[SRC_TXRDY]);
  // R8: an event beats a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_room_pulse && rd_isr) |=> pend_v[SRC_TXRDY]);
  // R10: code is nonzero exactly when the request line is high
  a_r10_id_vs_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_o == (irq_id != '0));
  // R10: code stays in range
  a_r10_id_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_id <= ID_W'(NSRC));
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk            (clk),
  .rst_sync_n     (rst_sync_n),
  .rx_empty       (rx_empty),
  .rx_tmo_pulse   (rx_tmo_pulse),
  .line_err_pulse (line_err_pulse),
  .tx_room_pulse  (tx_room_pulse),
  .rd_lsr         (rd_lsr),
  .rd_isr         (rd_isr),
  .pend_v         (pend_v),
  .irq_o          (irq_o),
  .irq_id         (irq_id)
);

// File: tb/uart_irq_status_tb.sv
`timescale 1ns/1ps
module uart_irq_status_tb;
  localparam int LVL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic [LVL_W-1:0] rx_trig = 8'd8;
  logic             rx_empty = 1'b0;
  logic             rx_tmo_pulse = 1'b0;
  logic             line_err_pulse = 1'b0;
  logic             tx_room_pulse = 1'b0;
  logic             modem_chg_pulse = 1'b0;
  logic             hshk_chg_pulse = 1'b0;
  logic             xoff_chg_pulse = 1'b0;
  logic             spec_chr_pulse = 1'b0;
  logic             rd_lsr = 1'b0;
  logic             rd_isr = 1'b0;
  logic             rd_msr = 1'b0;
  logic             en_we = 1'b0;
  logic [5:0]       en_wdata = '0;
  logic             irq_o;
  logic [2:0]       irq_id;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_status #(.LVL_W(LVL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .rx_trig(rx_trig),
    .rx_empty(rx_empty), .rx_tmo_pulse(rx_tmo_pulse),
    .line_err_pulse(line_err_pulse), .tx_room_pulse(tx_room_pulse),
    .modem_chg_pulse(modem_chg_pulse), .hshk_chg_pulse(hshk_chg_pulse),
    .xoff_chg_pulse(xoff_chg_pulse), .spec_chr_pulse(spec_chr_pulse),
    .rd_lsr(rd_lsr), .rd_isr(rd_isr), .rd_msr(rd_msr),
    .en_we(en_we), .en_wdata(en_wdata), .irq_o(irq_o), .irq_id(irq_id)
  );

  // Compare both outputs; an id of 0 implies irq low
  task automatic chk(input string tag, input logic [2:0] exp_id);
    logic exp_irq;
    exp_irq = (exp_id != 3'd0);
    total++;
    if (irq_id !== exp_id || irq_o !== exp_irq) begin
      bad++;
      $display("FAIL %s: id=%0d irq=%0b expected id=%0d irq=%0b",
               tag, irq_id, irq_o, exp_id, exp_irq);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_en(input logic [5:0] v);
    en_wdata = v; en_we = 1'b1; tick(); en_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset idle", 3'd0);
    line_err_pulse = 1'b1; tick(); line_err_pulse = 1'b0;
    chk("R1 enables cleared", 3'd0);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    wr_en(6'h3F);
    chk("R11 enable write visible next edge", 3'd0);
  endtask

  task automatic t_line();
    line_err_pulse = 1'b1; tick(); line_err_pulse = 1'b0;
    chk("R3 R11 line set", 3'd1);
    rd_isr = 1'b1; rd_msr = 1'b1; tick(); rd_isr = 1'b0; rd_msr = 1'b0;
    chk("R3 other reads keep line", 3'd1);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    chk("R3 lsr read clears", 3'd0);
  endtask

  task automatic t_rxrdy();
    rx_level = 8'd8; tick();
    chk("R2 level at trigger", 3'd3);
    rx_level = 8'd12; rd_isr = 1'b1; rd_lsr = 1'b1; rd_msr = 1'b1; tick();
    rd_isr = 1'b0; rd_lsr = 1'b0; rd_msr = 1'b0;
    chk("R2 reads do not clear", 3'd3);
    rx_level = 8'd7; tick();
    chk("R2 below trigger clears", 3'd0);
    rx_trig = 8'd4; tick();
    chk("R2 lowered trigger", 3'd3);
    rx_trig = 8'd8; rx_level = 8'd0; tick();
    chk("R2 drained", 3'd0);
  endtask

  task automatic t_tmo();
    rx_tmo_pulse = 1'b1; tick(); rx_tmo_pulse = 1'b0;
    chk("R4 timeout set", 3'd2);
    rd_isr = 1'b1; rd_lsr = 1'b1; rd_msr = 1'b1; tick();
    rd_isr = 1'b0; rd_lsr = 1'b0; rd_msr = 1'b0;
    chk("R4 reads do not clear", 3'd2);
    rx_empty = 1'b1; tick(); rx_empty = 1'b0;
    chk("R4 empty clears", 3'd0);
  endtask

  task automatic t_tx();
    tx_room_pulse = 1'b1; tick(); tx_room_pulse = 1'b0;
    chk("R5 tx set", 3'd4);
    rd_lsr = 1'b1; rd_msr = 1'b1; tick(); rd_lsr = 1'b0; rd_msr = 1'b0;
    chk("R5 other reads keep tx", 3'd4);
    rd_isr = 1'b1; tick(); rd_isr = 1'b0;
    chk("R5 isr read clears", 3'd0);
  endtask

  task automatic t_modem();
    hshk_chg_pulse = 1'b1; tick(); hshk_chg_pulse = 1'b0;
    chk("R6 handshake delta sets", 3'd5);
    rd_isr = 1'b1; rd_lsr = 1'b1; tick(); rd_isr = 1'b0; rd_lsr = 1'b0;
    chk("R6 other reads keep modem", 3'd5);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    chk("R6 msr read clears", 3'd0);
    modem_chg_pulse = 1'b1; tick(); modem_chg_pulse = 1'b0;
    chk("R6 modem change sets", 3'd5);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    chk("R6 cleared again", 3'd0);
  endtask

  task automatic t_flow();
    spec_chr_pulse = 1'b1; tick(); spec_chr_pulse = 1'b0;
    chk("R7 special char sets", 3'd6);
    rd_msr = 1'b1; rd_lsr = 1'b1; tick(); rd_msr = 1'b0; rd_lsr = 1'b0;
    chk("R7 other reads keep flow", 3'd6);
    rd_isr = 1'b1; tick(); rd_isr = 1'b0;
    chk("R7 isr read clears", 3'd0);
    xoff_chg_pulse = 1'b1; tick(); xoff_chg_pulse = 1'b0;
    chk("R7 xon/xoff delta sets", 3'd6);
    rd_isr = 1'b1; tick(); rd_isr = 1'b0;
    chk("R7 cleared again", 3'd0);
  endtask

  task automatic t_prio();
    line_err_pulse = 1'b1; rx_tmo_pulse = 1'b1; tx_room_pulse = 1'b1;
    modem_chg_pulse = 1'b1; spec_chr_pulse = 1'b1; rx_level = 8'd9; tick();
    line_err_pulse = 1'b0; rx_tmo_pulse = 1'b0; tx_room_pulse = 1'b0;
    modem_chg_pulse = 1'b0; spec_chr_pulse = 1'b0;
    chk("R10 all pending line wins", 3'd1);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    chk("R10 timeout next", 3'd2);
    rx_empty = 1'b1; tick(); rx_empty = 1'b0;
    chk("R10 rx ready next", 3'd3);
    rx_level = 8'd0; tick();
    chk("R10 tx ready next", 3'd4);
    rd_isr = 1'b1; tick(); rd_isr = 1'b0;
    chk("R10 modem after isr read", 3'd5);
    rd_msr = 1'b1; tick(); rd_msr = 1'b0;
    chk("R10 all cleared", 3'd0);
  endtask

  task automatic t_collide();
    line_err_pulse = 1'b1; rd_lsr = 1'b1; tick();
    line_err_pulse = 1'b0; rd_lsr = 1'b0;
    chk("R8 line event beats read", 3'd1);
    rd_lsr = 1'b1; tick(); rd_lsr = 1'b0;
    chk("R8 line then cleared", 3'd0);
    rx_tmo_pulse = 1'b1; rx_empty = 1'b1; tick();
    rx_tmo_pulse = 1'b0; rx_empty = 1'b0;
    chk("R8 timeout beats empty", 3'd2);
    rx_empty = 1'b1; tick(); rx_empty = 1'b0;
    chk("R8 timeout then cleared", 3'd0);
    spec_chr_pulse = 1'b1; rd_isr = 1'b1; tick();
    spec_chr_pulse = 1'b0; rd_isr = 1'b0;
    chk("R8 flow event beats read", 3'd6);
    rd_isr = 1'b1; tick(); rd_isr = 1'b0;
    chk("R8 flow then cleared", 3'd0);
  endtask

  task automatic t_mask();
    wr_en(6'h00);
    line_err_pulse = 1'b1; tick(); line_err_pulse = 1'b0;
    chk("R9 disabled line hidden", 3'd0);
    wr_en(6'h01);
    chk("R9 enabling reveals pending", 3'd1);
    wr_en(6'h08);
    tx_room_pulse = 1'b1; tick(); tx_room_pulse = 1'b0;
    chk("R9 masked line lets tx win", 3'd4);
    rd_isr = 1'b1; rd_lsr = 1'b1; tick(); rd_isr = 1'b0; rd_lsr = 1'b0;
    chk("R9 cleared", 3'd0);
    wr_en(6'h20);
    modem_chg_pulse = 1'b1; xoff_chg_pulse = 1'b1; tick();
    modem_chg_pulse = 1'b0; xoff_chg_pulse = 1'b0;
    chk("R9 only bit5 enabled", 3'd6);
    wr_en(6'h3F);
    chk("R9 full enable modem wins", 3'd5);
    rd_msr = 1'b1; rd_isr = 1'b1; tick(); rd_msr = 1'b0; rd_isr = 1'b0;
    chk("R9 final clear", 3'd0);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_line();
    t_rxrdy();
    t_tmo();
    t_tx();
    t_modem();
    t_flow();
    t_prio();
    t_collide();
    t_mask();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule